// File: doc/BRIEF.md
# Strobed Byte Host Link Interface

This block joins a host computer to a local peripheral processor over two one-way parallel paths. Each path has twelve lines and a strobe. The low eight lines of a word carry a data byte, and the upper four carry a command nibble (inbound) or a status nibble (outbound). Only the host can start an inbound transfer. It places a word on its lines and raises its strobe. The block synchronises the strobe, latches the word on the detected rising edge and raises a non-maskable interrupt request to the local processor. The request stays high until the processor reads the word.

For the other direction the local processor writes a word to the outbound register. The block presents the word on its lines, waits one cycle, then drives the outbound strobe high for a programmable number of cycles. That strobe acts as a program interrupt at the host. The word is held one further cycle after the strobe falls. The local processor reaches the block through a small register port with a select, a write enable, a two-bit address and combinational read data.

Top module: `hostlink_if`

## Requirements
- R1: After reset, `nmi_o` and `l_stb_o` are 0, `l_word_o` is 0, the status register reads 0 and the pulse-length register reads 4.
- R2: A rising edge on `h_stb_i` is seen through a two-stage synchroniser. The word on `h_word_i` is latched on the third rising clock edge after the strobe goes high ahead of a clock edge, and `nmi_o` is 1 from that edge on.
- R3: Only a rising edge of `h_stb_i` captures. Holding the strobe high for many cycles produces one capture.
- R4: Reading address 0 returns the latched word, with the command nibble in bits 11:8 and the data byte in bits 7:0. That read clears `nmi_o` and the overrun flag at the next edge.
- R5: If a capture happens while a word is still unread, the overrun flag (status bit 1) is set and the new word replaces the old one.
- R6: A capture on the same edge as a read of address 0 leaves the new word pending with `nmi_o` at 1 and does not set the overrun flag.
- R7: A write to address 1 while the outbound path is idle updates `l_word_o` at that edge. `l_stb_o` rises one cycle later.
- R8: `l_stb_o` stays high for exactly N cycles, where N is the value of the pulse-length register at address 3 (8 bits) taken when the strobe starts. A value of 0 acts as 1.
- R9: `l_word_o` stays unchanged for the cycle after `l_stb_o` falls.
- R10: A write to address 1 while the outbound path is busy is ignored: `l_word_o` and the pulse keep their current values.
- R11: The status register at address 2 has bit 0 = interrupt pending, bit 1 = overrun and bit 2 = outbound busy (from the write edge until the hold cycle ends). All other bits are 0. Address 1 reads back `l_word_o`. Read data is 0 when no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_word_i | input | 12 | Inbound word from the host (nibble in 11:8, byte in 7:0) |
| h_stb_i | input | 1 | Inbound strobe from the host, asynchronous |
| l_word_o | output | 12 | Outbound word to the host |
| l_stb_o | output | 1 | Outbound strobe, interrupt to the host |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 inbound word, 1 outbound word, 2 status, 3 pulse length |
| bus_wdata_i | input | 12 | Write data |
| bus_rdata_o | output | 12 | Read data, combinational |
| nmi_o | output | 1 | Interrupt request to the local processor |

## Verification
The bench aims at the exact capture latency. A synchroniser that is one stage short or long moves the edge on which `nmi_o` rises and fails the cycle-exact comparison. It also tests a held strobe, which a level-sensitive capture would keep latching. It forces a second word in before a read, to expose a design that keeps the old word or misses the overrun flag. It lines a capture up with a read on the same edge, where a design that lets the read win drops a pending word. On the outbound side it checks pulse widths of 4, 1 (for a programmed 0) and 7, and the hold cycles on both sides of the strobe. It also writes the outbound register during a pulse, which a design without busy gating would use to corrupt the word in flight.

// File: rtl/hl_pkg.sv
`timescale 1ns/1ps
package hl_pkg;
  typedef enum logic [1:0] {
    REG_INWORD  = 2'd0,
    REG_OUTWORD = 2'd1,
    REG_STATUS  = 2'd2,
    REG_PLEN    = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    OB_IDLE  = 2'd0,
    OB_LEAD  = 2'd1,
    OB_HIGH  = 2'd2,
    OB_TRAIL = 2'd3
  } ob_state_e;

  localparam int ST_PEND = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_BUSY = 2;
endpackage

// File: rtl/hl_rst_sync.sv
`timescale 1ns/1ps
module hl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hl_in_capture.sv
`timescale 1ns/1ps
module hl_in_capture #(
  parameter int W           = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb_async,
  input  logic [W-1:0] word_async,
  input  logic         rd_clr,
  output logic [W-1:0] word_q,
  output logic         pend_q,
  output logic         ovr_q,
  output logic         cap
);
  logic [SYNC_STAGES:0] shift_q;
  logic [SYNC_STAGES:0] shift_d;
  logic [W-1:0]         word_d;
  logic                 word_en;
  logic                 pend_d;
  logic                 ovr_d;

  assign cap = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];

  always_comb begin
    shift_d = {shift_q[SYNC_STAGES-1:0], stb_async};
    word_en = cap;
    word_d  = word_async;
    pend_d  = pend_q;
    ovr_d   = ovr_q;
    if (cap) begin
      pend_d = 1'b1;
      ovr_d  = rd_clr ? 1'b0 : (ovr_q | pend_q);
    end else if (rd_clr) begin
      pend_d = 1'b0;
      ovr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      pend_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      shift_q <= shift_d;
      pend_q  <= pend_d;
      ovr_q   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end
endmodule

// File: rtl/hl_out_strobe.sv
`timescale 1ns/1ps
module hl_out_strobe
  import hl_pkg::*;
#(
  parameter int W       = 12,
  parameter int LEN_W   = 8,
  parameter int DEF_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_word,
  input  logic [W-1:0]     wdata,
  input  logic             wr_len,
  input  logic [LEN_W-1:0] len_wdata,
  output logic [W-1:0]     word_q,
  output logic             stb_q,
  output logic             busy,
  output logic [LEN_W-1:0] len_q
);
  ob_state_e        state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             word_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    word_en = 1'b0;
    unique case (state_q)
      OB_IDLE: begin
        if (wr_word) begin
          word_en = 1'b1;
          state_d = OB_LEAD;
        end
      end
      OB_LEAD: begin
        cnt_d   = (len_q == '0) ? LEN_W'(1) : len_q;
        state_d = OB_HIGH;
      end
      OB_HIGH: begin
        if (cnt_q == LEN_W'(1)) state_d = OB_TRAIL;
        else                    cnt_d   = cnt_q - LEN_W'(1);
      end
      OB_TRAIL: state_d = OB_IDLE;
      default:  state_d = OB_IDLE;
    endcase
  end

  assign busy = (state_q != OB_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OB_IDLE;
      cnt_q   <= '0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      stb_q   <= (state_d == OB_HIGH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= LEN_W'(DEF_LEN);
    else if (wr_len) len_q <= len_wdata;
  end
endmodule

// File: rtl/hostlink_if.sv
`timescale 1ns/1ps
module hostlink_if
  import hl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CTL_W       = 4,
  parameter int LEN_W       = 8,
  parameter int DEF_LEN     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = DATA_W + CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] h_word_i,
  input  logic              h_stb_i,
  output logic [WORD_W-1:0] l_word_o,
  output logic              l_stb_o,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              nmi_o
);
  logic              rst_n_int;
  logic              rd_en, wr_en;
  logic              rd_in, wr_out, wr_len;
  logic [WORD_W-1:0] in_word;
  logic              in_pend, in_ovr, in_cap;
  logic              out_busy;
  logic [LEN_W-1:0]  plen;
  logic [WORD_W-1:0] status;

  hl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_int)
  );

  always_comb begin
    rd_en  = bus_sel_i & ~bus_we_i;
    wr_en  = bus_sel_i &  bus_we_i;
    rd_in  = rd_en & (bus_addr_i == REG_INWORD);
    wr_out = wr_en & (bus_addr_i == REG_OUTWORD);
    wr_len = wr_en & (bus_addr_i == REG_PLEN);
  end

  hl_in_capture #(.W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk(clk), .rst_n(rst_n_int),
    .stb_async(h_stb_i), .word_async(h_word_i), .rd_clr(rd_in),
    .word_q(in_word), .pend_q(in_pend), .ovr_q(in_ovr), .cap(in_cap)
  );

  hl_out_strobe #(.W(WORD_W), .LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_out (
    .clk(clk), .rst_n(rst_n_int),
    .wr_word(wr_out), .wdata(bus_wdata_i),
    .wr_len(wr_len), .len_wdata(bus_wdata_i[LEN_W-1:0]),
    .word_q(l_word_o), .stb_q(l_stb_o), .busy(out_busy), .len_q(plen)
  );

  always_comb begin
    status          = '0;
    status[ST_PEND] = in_pend;
    status[ST_OVR]  = in_ovr;
    status[ST_BUSY] = out_busy;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      unique case (bus_addr_i)
        REG_INWORD:  bus_rdata_o = in_word;
        REG_OUTWORD: bus_rdata_o = l_word_o;
        REG_STATUS:  bus_rdata_o = status;
        REG_PLEN:    bus_rdata_o = WORD_W'(plen);
        default:     bus_rdata_o = '0;
      endcase
    end
  end

  assign nmi_o = in_pend;
endmodule

// File: rtl/hl_checker.sv
`timescale 1ns/1ps
module hl_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         nmi,
  input logic         stb,
  input logic [W-1:0] word,
  input logic         rd_in,
  input logic         cap,
  input logic         ovr,
  input logic         busy,
  input logic         wr_out
);
  a_r2_capture_raises_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> nmi);

  a_r4_read_clears_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in && !cap) |=> !nmi);

  a_r5_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && nmi && !rd_in) |=> ovr);

  a_r6_no_overrun_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && rd_in) |=> (nmi && !ovr));

  a_r7_lead_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb) |-> $stable(word));

  a_r9_trail_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb) |=> $stable(word));

  a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_out) |=> $stable(word));
endmodule

bind hostlink_if hl_checker #(.W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi(nmi_o), .stb(l_stb_o), .word(l_word_o),
  .rd_in(rd_in), .cap(in_cap), .ovr(in_ovr), .busy(out_busy), .wr_out(wr_out)
);

// File: tb/hostlink_if_tb.sv
`timescale 1ns/1ps
module hostlink_if_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] h_word;
  logic        h_stb;
  logic [11:0] l_word;
  logic        l_stb;
  logic        sel, we;
  logic [1:0]  addr;
  logic [11:0] wdata;
  logic [11:0] rdata;
  logic        nmi;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  hostlink_if u_dut (
    .clk(clk), .rst_n(rst_n), .h_word_i(h_word), .h_stb_i(h_stb),
    .l_word_o(l_word), .l_stb_o(l_stb), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .nmi_o(nmi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit       m_s1, m_s2, m_s3, m_irq, m_ovr;
  int       m_word, m_oword, m_ost, m_cnt, m_len;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_irq = 0; m_ovr = 0;
      m_word = 0; m_oword = 0; m_ost = 0; m_cnt = 0; m_len = 4;
    end else begin
      bit rd0, wr1, wr3, c;
      rd0 = sel && !we && addr == 2'd0;
      wr1 = sel && we && addr == 2'd1;
      wr3 = sel && we && addr == 2'd3;
      c   = m_s2 && !m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = h_stb;
      if (c) begin
        m_ovr  = rd0 ? 1'b0 : (m_ovr | m_irq);
        m_irq  = 1;
        m_word = h_word;
      end else if (rd0) begin
        m_irq = 0; m_ovr = 0;
      end
      case (m_ost)
        0: if (wr1) begin m_oword = wdata; m_ost = 1; end
        1: begin m_cnt = (m_len == 0) ? 1 : m_len; m_ost = 2; end
        2: if (m_cnt == 1) m_ost = 3; else m_cnt--;
        default: m_ost = 0;
      endcase
      if (wr3) m_len = wdata[7:0];
    end
  end

  function automatic int exp_rdata();
    if (!(sel && !we)) return 0;
    case (addr)
      2'd0: return m_word;
      2'd1: return m_oword;
      2'd2: return {29'd0, m_ost != 0, m_ovr, m_irq};
      default: return m_len;
    endcase
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 nmi_o", nmi, m_irq);
      chk("R8 l_stb_o", l_stb, m_ost == 2);
      chk("R9 l_word_o", l_word, m_oword);
      chk("R4 bus_rdata_o", rdata, exp_rdata());
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk); #2;
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); #2;
    sel = 0; we = 0; wdata = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [11:0] d);
    @(negedge clk); #2;
    sel = 1; we = 0; addr = a;
    #5 d = rdata;
    @(negedge clk); #2;
    sel = 0;
  endtask

  task automatic host_send(input logic [11:0] w, input int hold);
    @(negedge clk); #2;
    h_word = w; h_stb = 1;
    repeat (hold) @(negedge clk);
    #2 h_stb = 0;
  endtask

  // measure a pulse after a write has just completed
  task automatic measure_pulse(input logic [11:0] w, output int width);
    bit seen;
    width = 0; seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      if (l_stb) begin width++; seen = 1; end
      else if (seen) begin
        chk("R9 hold after strobe", l_word, w);
        break;
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [11:0] d;
    int w;
    rst_n = 0; h_word = 0; h_stb = 0; sel = 0; we = 0; addr = 0; wdata = 0;
    repeat (4) @(negedge clk);
    #2 rst_n = 1;
    idle(4);

    // R1 reset state
    chk("R1 nmi", nmi, 0);
    chk("R1 strobe", l_stb, 0);
    chk("R1 word", l_word, 0);
    bus_rd(2'd3, d); chk("R1 plen", d, 4);
    bus_rd(2'd2, d); chk("R11 status idle", d, 0);

    // R2 latency, R3 held strobe
    @(negedge clk); #2;
    h_word = 12'hA5C; h_stb = 1;
    @(negedge clk); @(negedge clk); #1;
    chk("R2 not yet", nmi, 0);
    @(negedge clk); #1;
    chk("R2 raised", nmi, 1);
    idle(6);
    h_stb = 0; h_word = 12'h111;
    idle(4);
    bus_rd(2'd2, d); chk("R3 single capture", d, 12'h001);
    bus_rd(2'd0, d); chk("R4 word", d, 12'hA5C);
    idle(1); #0;
    chk("R4 nmi cleared", nmi, 0);

    // R5 overrun
    host_send(12'h3F0, 2); idle(4);
    host_send(12'hC81, 2); idle(4);
    bus_rd(2'd2, d); chk("R5 overrun status", d, 12'h003);
    bus_rd(2'd0, d); chk("R5 newest word", d, 12'hC81);
    bus_rd(2'd2, d); chk("R5 cleared", d, 0);

    // R6 capture coincides with read
    host_send(12'h2B4, 2); idle(4);
    @(negedge clk); #2;
    h_word = 12'h9E7; h_stb = 1;
    @(negedge clk); @(negedge clk); #2;
    sel = 1; we = 0; addr = 2'd0;
    @(negedge clk); #2;
    sel = 0; h_stb = 0;
    idle(2);
    bus_rd(2'd2, d); chk("R6 pending no overrun", d, 12'h001);
    bus_rd(2'd0, d); chk("R6 new word kept", d, 12'h9E7);

    // R7 R8 default pulse
    bus_wr(2'd1, 12'h3C7);
    chk("R7 word presented", l_word, 12'h3C7);
    chk("R7 strobe still low", l_stb, 0);
    measure_pulse(12'h3C7, w);
    chk("R8 default width", w, 4);
    idle(2);

    // R8 zero and seven
    bus_wr(2'd3, 12'h000);
    bus_wr(2'd1, 12'h5A1);
    measure_pulse(12'h5A1, w);
    chk("R8 zero acts as one", w, 1);
    idle(2);
    bus_wr(2'd3, 12'h007);
    bus_rd(2'd3, d); chk("R8 plen readback", d, 7);
    bus_wr(2'd1, 12'h0F2);
    bus_rd(2'd2, d); chk("R11 busy bit", d, 12'h004);
    bus_rd(2'd1, d); chk("R11 outbound readback", d, 12'h0F2);
    // R10 write during pulse
    bus_wr(2'd1, 12'hEEE);
    chk("R10 write ignored", l_word, 12'h0F2);
    idle(12);
    chk("R10 no second pulse", l_stb, 0);
    chk("R10 word unchanged", l_word, 12'h0F2);
    bus_wr(2'd1, 12'h6D3);
    measure_pulse(12'h6D3, w);
    chk("R8 width seven", w, 7);
    idle(3);
    bus_rd(2'd2, d); chk("R11 final status", d, 0);

    finish_run();
  end
endmodule